// File: doc/BRIEF.md
# Quadrature-Window Phase Lock Detector

This block is the digital part of the phase-lock check in a bang-bang clock and data recovery loop. Outside logic samples two clock levels at each data transition and presents them with a one-cycle transition strobe. The first level is the in-phase clock. Its falling edge is the phase target, so its level tells whether the data edge came before or after that falling edge. The second level is a quadrature clock, which is the in-phase clock delayed by a quarter of a unit interval. Around the expected transition position the quadrature clock forms a window that is high. A transition that finds it high counts as a hit, and one that finds it low counts as a miss.

The block registers the bi-level early/late decision. It folds each hit or miss into a 16-bit exponential moving average whose full scale stands for a ratio of 1.0. It exports the upper byte of that average as a jitter indicator. A loop that wanders freely scores near half scale, and a loop that tracks the data scores near full scale. The phase-lock flag rises once the average passes 0.66 of full scale. A hysteresis band of 1/64 full scale, centred on that threshold, keeps the flag steady. The averaging shift is a parameter, so the time constant can be set to span more than a video line of transitions.

Top module: `qwl_phase_lock_det`

## Requirements
- R1: While reset is low, and on the first cycle after it, the average holds half scale (32768), so the jitter indicator reads 0x80 (128), the lock flag reads 0 and the early/late output reads 0.
- R2: The early/late output equals the in-phase sample taken at the last strobed transition. A 1 means the transition came before the in-phase falling edge (early) and a 0 means it came after (late). Between strobes the output holds.
- R3: A strobed transition with the quadrature sample at 1 (hit) updates the average to avg + ((65536 - avg) >> K), where K is the shift parameter (default 6). A hit never lowers the average.
- R4: A strobed transition with the quadrature sample at 0 (miss) updates the average to avg - (avg >> K). A miss never raises the average.
- R5: While the strobe is low, the sample inputs have no effect. The average, the jitter indicator, the lock flag and the early/late output all keep their values.
- R6: The jitter indicator is bits 15:8 of the average.
- R7: The lock flag sets on a strobed transition whose updated average exceeds 43766, which is the threshold 43254 (0.66 of full scale) plus 512.
- R8: The lock flag clears on a strobed transition whose updated average falls below 42742, which is the threshold minus 512.
- R9: When the updated average lies from 42742 to 43766 inclusive, the lock flag keeps its previous value. Under an unbroken run of hits the average saturates below 65536, and the indicator settles at 0xFF.
- R10: All three outputs take their new values at the same rising clock edge that samples the strobe. No further pipeline stage follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| edge_stb_i | input | 1 | One cycle per data transition |
| inphase_smp_i | input | 1 | In-phase clock level at the transition |
| quad_smp_i | input | 1 | Quadrature clock level at the transition (1 = hit) |
| edge_early_o | output | 1 | Registered early/late decision (1 = early) |
| win_ratio_o | output | 8 | Upper byte of the window-hit average |
| phase_lock_o | output | 1 | Phase-lock flag with hysteresis |

## Verification
Every result of a strobed transition is due at the first rising edge that samples the strobe: the decision, the indicator byte and the lock flag. The bench therefore drives inputs on a falling edge. It compares all three outputs at the next falling edge against a reference that applies the same transition to its own 16-bit average. Idle cycles carry random sample levels, and the same next-falling-edge compare confirms that nothing moved. The lock flag is checked on every vector. Each check is tagged by whether the flag should have set, cleared or held for the reference average.

// File: rtl/qwl_pkg.sv
package qwl_pkg;

    // Bi-level phase decision encoding
    typedef enum logic {
        PD_LATE  = 1'b0,
        PD_EARLY = 1'b1
    } pd_dir_e;

    // Defaults shared by the modules of this block
    localparam int unsigned QWL_AVG_W   = 16;
    localparam int unsigned QWL_IND_W   = 8;
    localparam int unsigned QWL_SHIFT_K = 6;
    localparam int unsigned QWL_THR_PCT = 66;

    // Threshold in average units, rounded to nearest
    function automatic int unsigned qwl_thresh(input int unsigned avg_w,
                                               input int unsigned pct);
        return ((pct * (32'd1 << avg_w)) + 32'd50) / 32'd100;
    endfunction

    // Half of the hysteresis band: 1/128 of full scale
    function automatic int unsigned qwl_hyst_half(input int unsigned avg_w);
        return (32'd1 << avg_w) >> 7;
    endfunction

endpackage

// File: rtl/qwl_edge_sampler.sv
module qwl_edge_sampler
    import qwl_pkg::*;
(
    input  logic    clk_i,
    input  logic    rst_ni,
    input  logic    edge_stb_i,
    input  logic    inphase_smp_i,
    output pd_dir_e dir_o
);

    typedef struct packed {
        pd_dir_e dir;
    } samp_state_t;

    samp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (edge_stb_i) begin
            st_d.dir = inphase_smp_i ? PD_EARLY : PD_LATE;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.dir <= PD_LATE;
        end else begin
            st_q <= st_d;
        end
    end

    assign dir_o = st_q.dir;

endmodule

// File: rtl/qwl_hit_average.sv
module qwl_hit_average #(
    parameter int unsigned AVG_W   = 16,
    parameter int unsigned SHIFT_K = 6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             edge_stb_i,
    input  logic             hit_i,
    output logic [AVG_W-1:0] avg_next_o,
    output logic [AVG_W-1:0] avg_o
);

    localparam logic [AVG_W:0]   FULL_SCALE = {1'b1, {AVG_W{1'b0}}};
    localparam logic [AVG_W-1:0] HALF_SCALE = {1'b1, {(AVG_W-1){1'b0}}};

    typedef struct packed {
        logic [AVG_W-1:0] avg;
    } avg_state_t;

    avg_state_t st_d, st_q;

    logic [AVG_W:0]   gap;
    logic [AVG_W:0]   rise_step;
    logic [AVG_W-1:0] fall_step;

    always_comb begin
        gap       = FULL_SCALE - {1'b0, st_q.avg};
        rise_step = gap >> SHIFT_K;
        fall_step = st_q.avg >> SHIFT_K;
        st_d      = st_q;
        if (edge_stb_i) begin
            if (hit_i) begin
                st_d.avg = st_q.avg + rise_step[AVG_W-1:0];
            end else begin
                st_d.avg = st_q.avg - fall_step;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.avg <= HALF_SCALE;
        end else begin
            st_q <= st_d;
        end
    end

    assign avg_next_o = st_d.avg;
    assign avg_o      = st_q.avg;

endmodule

// File: rtl/qwl_lock_hyst.sv
module qwl_lock_hyst #(
    parameter int unsigned AVG_W   = 16,
    parameter int unsigned THR_VAL = 43254,
    parameter int unsigned HYST_HF = 512
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             edge_stb_i,
    input  logic [AVG_W-1:0] avg_next_i,
    output logic             lock_o
);

    localparam logic [AVG_W-1:0] SET_LVL = AVG_W'(THR_VAL + HYST_HF);
    localparam logic [AVG_W-1:0] CLR_LVL = AVG_W'(THR_VAL - HYST_HF);

    typedef struct packed {
        logic lock;
    } lock_state_t;

    lock_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (edge_stb_i) begin
            if (avg_next_i > SET_LVL) begin
                st_d.lock = 1'b1;
            end else if (avg_next_i < CLR_LVL) begin
                st_d.lock = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.lock <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lock_o = st_q.lock;

endmodule

// File: rtl/qwl_phase_lock_det.sv
module qwl_phase_lock_det
    import qwl_pkg::*;
#(
    parameter int unsigned AVG_W   = QWL_AVG_W,
    parameter int unsigned IND_W   = QWL_IND_W,
    parameter int unsigned SHIFT_K = QWL_SHIFT_K,
    parameter int unsigned THR_PCT = QWL_THR_PCT
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             edge_stb_i,
    input  logic             inphase_smp_i,
    input  logic             quad_smp_i,
    output logic             edge_early_o,
    output logic [IND_W-1:0] win_ratio_o,
    output logic             phase_lock_o
);

    localparam int unsigned THR_VAL = qwl_thresh(AVG_W, THR_PCT);
    localparam int unsigned HYST_HF = qwl_hyst_half(AVG_W);

    pd_dir_e          dir;
    logic [AVG_W-1:0] avg_next;
    logic [AVG_W-1:0] avg;

    qwl_edge_sampler u_samp (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .edge_stb_i    (edge_stb_i),
        .inphase_smp_i (inphase_smp_i),
        .dir_o         (dir)
    );

    qwl_hit_average #(
        .AVG_W   (AVG_W),
        .SHIFT_K (SHIFT_K)
    ) u_avg (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .edge_stb_i (edge_stb_i),
        .hit_i      (quad_smp_i),
        .avg_next_o (avg_next),
        .avg_o      (avg)
    );

    qwl_lock_hyst #(
        .AVG_W   (AVG_W),
        .THR_VAL (THR_VAL),
        .HYST_HF (HYST_HF)
    ) u_lock (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .edge_stb_i (edge_stb_i),
        .avg_next_i (avg_next),
        .lock_o     (phase_lock_o)
    );

    assign edge_early_o = (dir == PD_EARLY);
    assign win_ratio_o  = avg[AVG_W-1 -: IND_W];

endmodule

// File: rtl/qwl_phase_lock_chk.sv
module qwl_phase_lock_chk
    import qwl_pkg::*;
#(
    parameter int unsigned AVG_W   = QWL_AVG_W,
    parameter int unsigned IND_W   = QWL_IND_W,
    parameter int unsigned THR_PCT = QWL_THR_PCT
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             edge_stb_i,
    input logic             inphase_smp_i,
    input logic             quad_smp_i,
    input logic             edge_early_o,
    input logic [IND_W-1:0] win_ratio_o,
    input logic             phase_lock_o
);

    localparam int unsigned THR_VAL = qwl_thresh(AVG_W, THR_PCT);
    localparam int unsigned HYST_HF = qwl_hyst_half(AVG_W);
    localparam logic [IND_W-1:0] SET_IND = IND_W'((THR_VAL + HYST_HF) >> (AVG_W - IND_W));
    localparam logic [IND_W-1:0] CLR_IND = IND_W'((THR_VAL - HYST_HF) >> (AVG_W - IND_W));

    assert_decision_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        edge_stb_i |=> (edge_early_o == $past(inphase_smp_i)));

    assert_hit_no_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (edge_stb_i && quad_smp_i) |=> (win_ratio_o >= $past(win_ratio_o)));

    assert_hit_keeps_lock_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (edge_stb_i && quad_smp_i && phase_lock_o) |=> phase_lock_o);

    assert_miss_no_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (edge_stb_i && !quad_smp_i) |=> (win_ratio_o <= $past(win_ratio_o)));

    assert_idle_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !edge_stb_i |=> ($stable(win_ratio_o) && $stable(phase_lock_o) && $stable(edge_early_o)));

    assert_set_level_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(phase_lock_o) |-> (win_ratio_o >= SET_IND));

    assert_clear_level_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(phase_lock_o) |-> (win_ratio_o <= CLR_IND));

endmodule

bind qwl_phase_lock_det qwl_phase_lock_chk #(
    .AVG_W   (AVG_W),
    .IND_W   (IND_W),
    .THR_PCT (THR_PCT)
) chk_i (.*);

// File: tb/qwl_phase_lock_det_tb_top.sv
module qwl_phase_lock_det_tb_top;

    localparam int unsigned K      = 6;
    localparam int unsigned SET_TH = 43766;
    localparam int unsigned CLR_TH = 42742;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stb = 1'b0;
    logic       ip = 1'b0;
    logic       qd = 1'b0;
    logic       early;
    logic [7:0] ratio;
    logic       lock;

    int unsigned m_avg = 32768;
    bit          m_lock = 1'b0;
    bit          m_early = 1'b0;
    int          vectors = 0;
    int          misses = 0;

    always #5 clk = ~clk;

    qwl_phase_lock_det dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .edge_stb_i    (stb),
        .inphase_smp_i (ip),
        .quad_smp_i    (qd),
        .edge_early_o  (early),
        .win_ratio_o   (ratio),
        .phase_lock_o  (lock)
    );

    function automatic int unsigned ema_next(int unsigned a, bit hit);
        if (hit) return a + ((32'd65536 - a) >> K);
        return a - (a >> K);
    endfunction

    task automatic check(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive at a falling edge; results due at the next rising edge (R10),
    // compared at the following falling edge.
    task automatic apply(bit s, bit i, bit q);
        string rtag;
        string ltag;
        bit    old_lock;
        stb = s; ip = i; qd = q;
        old_lock = m_lock;
        if (s) begin
            m_early = i;
            m_avg   = ema_next(m_avg, q);
            if (m_avg > SET_TH) m_lock = 1'b1;
            else if (m_avg < CLR_TH) m_lock = 1'b0;
            rtag = q ? "R3/R6 hit ratio" : "R4/R6 miss ratio";
        end else begin
            rtag = "R5 idle ratio";
        end
        if (!s) ltag = "R5 idle lock";
        else if (m_lock && !old_lock) ltag = "R7 lock set";
        else if (!m_lock && old_lock) ltag = "R8 lock clear";
        else ltag = "R9 lock hold";
        @(negedge clk);
        check(s ? "R2 early/late" : "R5 idle early/late", int'(early), int'(m_early));
        check(rtag, int'(ratio), int'(m_avg >> 8));
        check(ltag, int'(lock), int'(m_lock));
    endtask

    initial begin
        #2_000_000;
        misses++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        check("R1 reset ratio", int'(ratio), 128);
        check("R1 reset lock", int'(lock), 0);
        check("R1 reset early/late", int'(early), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 post-reset ratio", int'(ratio), 128);
        check("R1 post-reset lock", int'(lock), 0);

        // Directed: idle with toggling samples changes nothing (R5)
        for (int n = 0; n < 8; n++) apply(1'b0, n[0], n[1]);
        // Early then late decisions (R2)
        apply(1'b1, 1'b1, 1'b0);
        apply(1'b0, 1'b0, 1'b1);
        apply(1'b1, 1'b0, 1'b1);
        // Unbroken hits: lock sets, ratio saturates at 0xFF (R7, R9)
        for (int n = 0; n < 400; n++) apply(1'b1, n[0], 1'b1);
        check("R9 saturation", int'(ratio), 255);
        // Unbroken misses: lock clears (R8)
        for (int n = 0; n < 60; n++) apply(1'b1, n[1], 1'b0);
        check("R8 cleared after misses", int'(lock), 0);
        // Walk across the hysteresis band slowly (R9)
        for (int n = 0; n < 300; n++) apply(1'b1, 1'b0, (n % 3) != 0);

        // Random segments at several hit probabilities
        for (int seg = 0; seg < 6; seg++) begin
            int unsigned pct;
            pct = (seg % 3 == 0) ? 90 : ((seg % 3 == 1) ? 50 : 67);
            for (int n = 0; n < 500; n++) begin
                bit s;
                s = ($urandom % 4) != 0;
                apply(s, $urandom % 2 == 1, ($urandom % 100) < pct);
            end
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule